// File: doc/BRIEF.md
# Timing-Mode Sampler with Glitch Flag

This block is the timing-mode front end of a small logic-analyzer core. It watches a set of digital channels on the analyzer's own fast sample clock, which runs independently of the clock of the circuit under test. Each channel's input is already digital. It arrives as a short vector of sub-sample observations, so the logic stays fully synchronous. On every sample tick the block emits one record. The record holds the sampled level of each channel, a per-channel edge flag and a per-channel glitch flag. A separate capture block stores these records.

The sampled level only shows where a channel ended up at each sample point. A pulse that starts and ends between two sample points leaves no trace in the levels. To catch it, the block counts transition activity across the whole interval and compares that activity with the change in the sampled value. Activity with no net change is reported as a glitch at the sample point that closes the interval. A net change is reported as an ordinary edge at that sample point, even if the real transition happened earlier in the interval.

Top module: `glitch_sampler`

## Requirements
- R1: On a tick, channel c's sampled level becomes bit S-1 of its slice `sub_obs[c*S +: S]`. Within a slice, bit 0 is the earliest observation and bit S-1 is the observation at the sample point. `smp` shows the new level from the clock after the tick.
- R2: `rec_valid` is high for exactly the one clock that follows each clock with `tick` high. It is low after any clock with `tick` low.
- R3: In a valid record, `edge_o[c]` is 1 exactly when channel c's new sampled level differs from the level sampled at the previous tick.
- R4: In a valid record, `glitch_o[c]` is 1 exactly when the new level equals the previous sampled level and at least one transition was seen in the interval. A transition is any pair of adjacent differing observations.
- R5: The pair formed by the previous sampled level and bit 0 of the current slice counts as a transition. A pulse held only in the first observations of an interval is therefore flagged.
- R6: `edge_o[c]` and `glitch_o[c]` are never both 1. Both are all zero whenever `rec_valid` is low.
- R7: A synchronous active-low reset clears `smp`, `edge_o`, `glitch_o`, `rec_valid` and the stored previous level. The first record after reset carries no edge or glitch bits.
- R8: Clocks without `tick` do not affect the result. `sub_obs` is ignored in those clocks, `smp` holds its value, and the next tick compares against the level of the last tick.
- R9: Channels are classified independently. The pattern on one channel never changes the flags of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | High in a clock whose `sub_obs` closes a sample interval |
| sub_obs | input | N_CH*SUB | Sub-sample observations, S bits per channel, bit 0 earliest |
| rec_valid | output | 1 | The record on the outputs is new this clock |
| smp | output | N_CH | Sampled level per channel |
| edge_o | output | N_CH | Level changed since the previous tick |
| glitch_o | output | N_CH | Activity seen but level unchanged since the previous tick |

## Verification
The assertions assume that `rst_n` is held low across at least one rising clock before any record matters. They also assume that each `sub_obs` vector is already the full, ordered set of observations for its interval, so that bit S-1 really is the level at the sample point. The bench drives reset low from time zero and changes every input only at the falling clock. It generates each slice as a whole ordered interval. Between ticks it scrambles `sub_obs` on purpose to show that idle clocks are ignored.

// File: rtl/glt_pkg.sv
// Package glt_pkg
// Shared types of the timing-mode glitch sampler.
// Assumes: nothing beyond IEEE 1800-2017.
package glt_pkg;

    // One channel's share of an output record.
    typedef struct packed {
        logic lvl;   // sampled level
        logic edg;   // net change since the previous tick
        logic glt;   // activity without net change
    } lane_rec_t;

endpackage

// File: rtl/glt_activity.sv
// Module glt_activity
// Reports whether any transition occurred in one channel's interval.
// The observation chain starts with the previous sampled level and
// continues with obs[0] .. obs[SUB-1] in time order.
// Assumes: SUB >= 1; purely combinational.
module glt_activity #(
    parameter int SUB = 4
) (
    input  logic           prev_lvl,
    input  logic [SUB-1:0] obs,
    output logic           moved
);

    logic [SUB-1:0] diff;

    // Boundary pair: previous sample point against the first observation.
    assign diff[0] = prev_lvl ^ obs[0];

    // Adjacent pairs inside the interval.
    for (genvar k = 1; k < SUB; k++) begin : g_pair
        assign diff[k] = obs[k] ^ obs[k-1];
    end

    // Any differing pair counts as activity.
    assign moved = |diff;

endmodule

// File: rtl/glt_lane.sv
// Module glt_lane
// Holds one channel's previous sampled level and classifies each
// interval as an edge, a glitch or neither.
// Assumes: 'armed' is low for the first tick after reset; rst_n is
// synchronous and active low.
module glt_lane
    import glt_pkg::*;
#(
    parameter int SUB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           armed,
    input  logic [SUB-1:0] obs,
    output lane_rec_t      rec
);

    logic prev_q;
    logic edg_q;
    logic glt_q;
    logic cur_lvl;
    logic moved;
    logic edg_d;
    logic glt_d;

    glt_activity #(.SUB(SUB)) u_act (
        .prev_lvl (prev_q),
        .obs      (obs),
        .moved    (moved)
    );

    // Classify the closing interval against the stored level.
    always_comb begin
        cur_lvl = obs[SUB-1];
        edg_d   = armed && (cur_lvl != prev_q);
        glt_d   = armed && moved && (cur_lvl == prev_q);
    end

    // Register the level and flags on a tick; flags drop between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            edg_q  <= 1'b0;
            glt_q  <= 1'b0;
        end else if (tick) begin
            prev_q <= cur_lvl;
            edg_q  <= edg_d;
            glt_q  <= glt_d;
        end else begin
            edg_q  <= 1'b0;
            glt_q  <= 1'b0;
        end
    end

    assign rec = '{lvl: prev_q, edg: edg_q, glt: glt_q};

endmodule

// File: rtl/glt_ctrl.sv
// Module glt_ctrl
// Record strobe and first-tick suppression shared by all lanes.
// Assumes: rst_n is synchronous and active low.
module glt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic armed,
    output logic rec_valid
);

    // Arm after the first tick; the strobe follows each tick by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            rec_valid <= 1'b0;
        end else begin
            rec_valid <= tick;
            if (tick) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/glitch_sampler.sv
// Module glitch_sampler
// Timing-mode front end: samples N_CH channels once per tick. For each
// channel it reports the level, a net-change edge flag and a glitch
// flag for activity that left no net change.
// Assumes: sub_obs holds SUB ordered observations per channel
// (bit 0 earliest, bit SUB-1 at the sample point).
module glitch_sampler
    import glt_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int SUB  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [N_CH*SUB-1:0] sub_obs,
    output logic                rec_valid,
    output logic [N_CH-1:0]     smp,
    output logic [N_CH-1:0]     edge_o,
    output logic [N_CH-1:0]     glitch_o
);

    localparam int OBS_W = N_CH * SUB;

    logic      armed;
    lane_rec_t lane_rec [N_CH];

    glt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .armed     (armed),
        .rec_valid (rec_valid)
    );

    // One independent lane per channel.
    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        glt_lane #(.SUB(SUB)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .armed (armed),
            .obs   (sub_obs[c*SUB +: SUB]),
            .rec   (lane_rec[c])
        );

        // Flatten lane records onto the output vectors.
        assign smp[c]      = lane_rec[c].lvl;
        assign edge_o[c]   = lane_rec[c].edg;
        assign glitch_o[c] = lane_rec[c].glt;
    end

    // Static check that the observation bus width is consistent.
    initial begin
        if (OBS_W != $bits(sub_obs)) $error("sub_obs width mismatch");
    end

endmodule

// File: rtl/glitch_sampler_chk.sv
// Module glitch_sampler_chk
// Port-level checker for glitch_sampler, bound to every instance.
// Tracks the last valid sampled level on its own.
// Assumes: reset is low at the first rising clock.
module glitch_sampler_chk #(
    parameter int N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            rec_valid,
    input logic [N_CH-1:0] smp,
    input logic [N_CH-1:0] edge_o,
    input logic [N_CH-1:0] glitch_o
);

    logic [N_CH-1:0] last_lvl;
    logic            have_prev;

    // Remember the level of the most recent valid record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_lvl  <= '0;
            have_prev <= 1'b0;
        end else if (rec_valid) begin
            last_lvl  <= smp;
            have_prev <= 1'b1;
        end
    end

    p_valid_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> rec_valid);

    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !rec_valid);

    p_edge_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && have_prev) |-> (edge_o == (smp ^ last_lvl)));

    p_glitch_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ((glitch_o & (smp ^ last_lvl)) == '0));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o & glitch_o) == '0);

    p_flags_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> (edge_o == '0 && glitch_o == '0));

    p_first_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !have_prev) |-> (edge_o == '0 && glitch_o == '0));

    p_hold_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_valid && have_prev) |-> $stable(smp));

endmodule

bind glitch_sampler glitch_sampler_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rec_valid (rec_valid),
    .smp       (smp),
    .edge_o    (edge_o),
    .glitch_o  (glitch_o)
);

// File: tb/tb_glitch_sampler.sv
// Bench tb_glitch_sampler
// Behavioural reference model compared with the outputs on every clock.
module tb_glitch_sampler;

    localparam int N  = 8;
    localparam int S  = 4;
    localparam int W  = N * S;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] sub_obs = '0;
    logic         rec_valid;
    logic [N-1:0] smp, edge_o, glitch_o;

    int    total = 0;
    int    bad   = 0;
    string phase = "R7 reset";

    // Model state.
    int           m_prev [N];
    bit           m_armed = 0;
    logic         e_valid = 0;
    logic [N-1:0] e_smp = '0, e_edge = '0, e_glt = '0;

    glitch_sampler #(.N_CH(N), .SUB(S)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sub_obs(sub_obs),
        .rec_valid(rec_valid), .smp(smp), .edge_o(edge_o), .glitch_o(glitch_o)
    );

    always #10 clk = ~clk;

    task automatic cmp(string req, logic [N-1:0] got, logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s [%s] got=%b exp=%b t=%0t", req, phase, got, exp, $time);
        end
    endtask

    // Compare the last record, then drive the next inputs and advance the model.
    task automatic step(logic t, logic [W-1:0] o, logic r);
        @(negedge clk);
        cmp("R2", {{(N-1){1'b0}}, rec_valid}, {{(N-1){1'b0}}, e_valid});
        cmp("R1", smp, e_smp);
        cmp("R3", edge_o, e_edge);
        cmp("R4", glitch_o, e_glt);
        cmp("R6", edge_o & glitch_o, '0);
        tick = t; sub_obs = o; rst_n = r;
        if (!r) begin
            foreach (m_prev[c]) m_prev[c] = 0;
            m_armed = 0; e_valid = 0; e_smp = '0; e_edge = '0; e_glt = '0;
        end else if (t) begin
            for (int c = 0; c < N; c++) begin
                int lvl = m_prev[c];
                int changes = 0;
                for (int k = 0; k < S; k++) begin
                    int b = o[c*S + k];
                    if (b != lvl) changes++;
                    lvl = b;
                end
                e_smp[c]  = lvl[0];
                e_edge[c] = m_armed && (lvl != m_prev[c]);
                e_glt[c]  = m_armed && (lvl == m_prev[c]) && (changes > 0);
                m_prev[c] = lvl;
            end
            m_armed = 1; e_valid = 1;
        end else begin
            e_valid = 0; e_edge = '0; e_glt = '0;
        end
    endtask

    function automatic logic [W-1:0] fill(logic [S-1:0] pat);
        logic [W-1:0] v;
        for (int c = 0; c < N; c++) v[c*S +: S] = pat;
        return v;
    endfunction

    initial begin
        foreach (m_prev[c]) m_prev[c] = 0;
        step(0, '0, 0);
        step(0, '0, 0);
        phase = "R7 first record";
        step(1, fill(4'b1011), 1);
        step(0, '0, 1);
        phase = "R5 boundary pulse";            // prev 1, obs 1110: low only at bit 0
        step(1, fill(4'b1110), 1);
        phase = "R4 inner pulse";
        step(1, fill(4'b1111), 1);
        step(1, fill(4'b0000), 1);
        step(1, fill(4'b0100), 1);
        phase = "R3 early edge";
        step(1, fill(4'b1111), 1);
        step(1, fill(4'b1000), 1);
        phase = "R8 idle ignored";
        step(0, 32'hA5A5_5A5A, 1);
        step(0, 32'h3C3C_C3C3, 1);
        step(1, fill(4'b1111), 1);
        step(0, 32'h0F0F_F0F0, 1);
        step(1, fill(4'b1111), 1);
        phase = "R9 mixed channels";
        step(1, 32'h0F1E_2D3C, 1);
        step(1, 32'hF0E1_D2C3, 1);
        phase = "random";
        for (int i = 0; i < 3000; i++) begin
            logic t = ($urandom_range(0, 9) < 7);
            logic r = !(i == 1500);
            if (i == 1501) phase = "R7 mid-run reset";
            if (i == 1510) phase = "random";
            step(t, W'($urandom()), r);
        end
        step(0, '0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule